// File: doc/BRIEF.md
# Self-Synchronizing Serial Pattern Detector

This block checks a serial NRZ bit stream against the test pattern it is supposed to carry. The stream arrives on its own receive clock, which may be gapped. The pattern is either a pseudorandom sequence or a short repeating word. A hold input gates sampling, and an invert control flips each bit before it is compared. The detector builds its local reference by seeding it from the incoming bits. Once the reference has proved itself over a run of clean compares, the detector declares lock. From then on the reference runs free, so a single bad bit on the line shows up as one error and is not propagated.

While locked, every mismatching bit raises a one-cycle error strobe, which feeds an external error counter. A burst of errors inside a fixed window drops the lock, and acquisition starts over. The block also keeps the last 32 received bits. A rising edge on a load strobe, formed as the OR of a pin and a control bit, copies those bits into a readable capture register.

Top module: `rx_pattern_checker`

## Requirements
- R1: After reset, in_sync is 0, bit_err is 0 and snap is all zeros.
- R2: A sample is taken on each rising clock edge while rx_hold is 0. The compared bit is rx_bit XOR rx_inv.
- R3: With cfg_rep=0, the expected bit is the XOR of the bits received cfg_len+1 and cfg_tap+1 samples earlier. This gives the sequence of the polynomial x^(cfg_len+1)+x^(cfg_tap+1)+1. With cfg_rep=1, the expected bit equals the bit cfg_len+1 samples earlier, which is a repeating word of period cfg_len+1. A wrong period never locks.
- R4: From reset, or after a loss of lock, the first 32 samples only seed the reference. After that, 32 consecutive matching compares set in_sync at the edge of the last one, which is the 64th sample of a clean stream. Any mismatch restarts the run.
- R5: bit_err is high for exactly one enabled cycle after the edge that sampled a mismatching bit, and only while locked. During acquisition it stays 0.
- R6: While locked, the reference runs free. Each isolated flipped bit produces exactly one bit_err pulse.
- R7: While locked, compares are grouped into fixed blocks of 64 that start at lock. The 6th error inside one block clears in_sync at that edge, and that error is still flagged on bit_err. Errors split across two blocks do not add together.
- R8: After a loss of lock, re-lock takes 32 seeding samples plus 32 clean compares.
- R9: While rx_hold is 1, the block samples nothing. in_sync and snap keep their values, bit_err is 0, and the stream resumes without errors when the hold ends.
- R10: On an enabled edge where ld_pin|ld_ctl is 1 and was 0 at the previous enabled edge, snap takes the 32 previously sampled post-invert bits. snap[0] is the most recent bit. Holding the strobe high captures nothing more.
- R11: Strobe edge detection is frozen during hold. A strobe that rises while rx_hold is 1 is captured at the first enabled edge if it is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, may be gapped |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data |
| rx_hold | input | 1 | 1 = do not sample, freeze all state |
| rx_inv | input | 1 | 1 = invert data before compare |
| ld_pin | input | 1 | Capture strobe from a pin |
| ld_ctl | input | 1 | Capture strobe from a control bit |
| cfg_rep | input | 1 | 1 = repeating word, 0 = pseudorandom |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Feedback tap minus one (pseudorandom only) |
| bit_err | output | 1 | One-cycle error strobe while locked |
| in_sync | output | 1 | Pattern lock status |
| snap | output | 32 | Captured last 32 bits, bit 0 newest |

## Verification
bit_err and in_sync are registered, so each is due right after the very edge that samples the responsible bit. in_sync rises after the edge of the 64th clean sample. The 6th in-block error clears in_sync and raises bit_err at that same edge. snap updates after the edge where the strobe's rise is first seen. The bench drives each bit on a falling edge and reads the outputs at the next falling edge, one sampling edge later, so every check lands one edge after its stimulus. Bits held during rx_hold are not counted.

// File: rtl/patdet_pkg.sv
package patdet_pkg;
   typedef enum logic {ST_ACQ = 1'b0, ST_LOCK = 1'b1} lock_state_t;
endpackage

// File: rtl/patdet_capture.sv
module patdet_capture #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         d,
   input  logic         ld,
   output logic [W-1:0] snap
);
   logic [W-1:0] hist;
   logic         ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         ld_q <= 1'b0;
         snap <= '0;
      end else if (en) begin
         hist <= {hist[W-2:0], d};
         ld_q <= ld;
         if (ld && !ld_q) snap <= hist;
      end
   end
endmodule

// File: rtl/patdet_reference.sv
module patdet_reference #(
   parameter int W            = 32,
   parameter bit ALLOW_REPEAT = 1'b1,
   localparam int IDXW        = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            locked,
   input  logic            d,
   input  logic            cfg_rep,
   input  logic [IDXW-1:0] cfg_len,
   input  logic [IDXW-1:0] cfg_tap,
   output logic            pred
);
   logic [W-1:0] ref_q;
   logic         lfsr_bit;

   assign lfsr_bit = ref_q[cfg_len] ^ ref_q[cfg_tap];

   generate
      if (ALLOW_REPEAT) begin : g_both
         assign pred = cfg_rep ? ref_q[cfg_len] : lfsr_bit;
      end else begin : g_lfsr_only
         logic unused_rep;
         assign unused_rep = cfg_rep;
         assign pred = lfsr_bit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ref_q <= '0;
      else if (en) ref_q <= {ref_q[W-2:0], locked ? pred : d};
   end
endmodule

// File: rtl/patdet_lock_ctrl.sv
module patdet_lock_ctrl
   import patdet_pkg::*;
#(
   parameter int FILL_LEN  = 32,
   parameter int LOCK_RUN  = 32,
   parameter int WIN_LEN   = 64,
   parameter int LOSS_ERRS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mismatch,
   output logic in_sync,
   output logic bit_err
);
   localparam int FILLW = $clog2(FILL_LEN + 1);
   localparam int RUNW  = $clog2(LOCK_RUN);
   localparam int WINW  = $clog2(WIN_LEN);
   localparam int ERRW  = $clog2(LOSS_ERRS);
   localparam logic [FILLW-1:0] FILL_DONE = FILLW'(FILL_LEN);
   localparam logic [RUNW-1:0]  RUN_LAST  = RUNW'(LOCK_RUN - 1);
   localparam logic [WINW-1:0]  WIN_LAST  = WINW'(WIN_LEN - 1);
   localparam logic [ERRW-1:0]  ERR_LAST  = ERRW'(LOSS_ERRS - 1);

   lock_state_t      state;
   logic [FILLW-1:0] fill;
   logic [RUNW-1:0]  run;
   logic [WINW-1:0]  win;
   logic [ERRW-1:0]  errs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_ACQ;
         fill    <= '0;
         run     <= '0;
         win     <= '0;
         errs    <= '0;
         bit_err <= 1'b0;
      end else begin
         bit_err <= 1'b0;
         if (en) begin
            if (state == ST_ACQ) begin
               if (fill != FILL_DONE) begin
                  fill <= fill + FILLW'(1);
                  run  <= '0;
               end else if (mismatch) begin
                  run <= '0;
               end else if (run == RUN_LAST) begin
                  state <= ST_LOCK;
                  run   <= '0;
                  win   <= '0;
                  errs  <= '0;
               end else begin
                  run <= run + RUNW'(1);
               end
            end else begin
               bit_err <= mismatch;
               if (mismatch && errs == ERR_LAST) begin
                  state <= ST_ACQ;
                  fill  <= '0;
                  run   <= '0;
               end else if (win == WIN_LAST) begin
                  win  <= '0;
                  errs <= '0;
               end else begin
                  win <= win + WINW'(1);
                  if (mismatch) errs <= errs + ERRW'(1);
               end
            end
         end
      end
   end

   assign in_sync = (state == ST_LOCK);
endmodule

// File: rtl/rx_pattern_checker.sv
module rx_pattern_checker #(
   parameter int W            = 32,
   parameter int LOCK_RUN     = 32,
   parameter int WIN_LEN      = 64,
   parameter int LOSS_ERRS    = 6,
   parameter bit ALLOW_REPEAT = 1'b1,
   localparam int IDXW        = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_bit,
   input  logic            rx_hold,
   input  logic            rx_inv,
   input  logic            ld_pin,
   input  logic            ld_ctl,
   input  logic            cfg_rep,
   input  logic [IDXW-1:0] cfg_len,
   input  logic [IDXW-1:0] cfg_tap,
   output logic            bit_err,
   output logic            in_sync,
   output logic [W-1:0]    snap
);
   generate
      if (W < 4 || W > 64) begin : g_bad_width
         $error("rx_pattern_checker: W must lie in 4..64");
      end
      if (LOCK_RUN < 2) begin : g_bad_run
         $error("rx_pattern_checker: LOCK_RUN must be at least 2");
      end
      if (LOSS_ERRS < 2 || WIN_LEN < LOSS_ERRS) begin : g_bad_window
         $error("rx_pattern_checker: need 2 <= LOSS_ERRS <= WIN_LEN");
      end
   endgenerate

   logic en, d, pred, mismatch;

   assign en       = ~rx_hold;
   assign d        = rx_bit ^ rx_inv;
   assign mismatch = d ^ pred;

   patdet_reference #(.W(W), .ALLOW_REPEAT(ALLOW_REPEAT)) u_ref (
      .clk(clk), .rst_n(rst_n), .en(en), .locked(in_sync), .d(d),
      .cfg_rep(cfg_rep), .cfg_len(cfg_len), .cfg_tap(cfg_tap), .pred(pred)
   );

   patdet_lock_ctrl #(.FILL_LEN(W), .LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN),
                      .LOSS_ERRS(LOSS_ERRS)) u_lock (
      .clk(clk), .rst_n(rst_n), .en(en), .mismatch(mismatch),
      .in_sync(in_sync), .bit_err(bit_err)
   );

   patdet_capture #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_n), .en(en), .d(d), .ld(ld_pin | ld_ctl), .snap(snap)
   );
endmodule

// File: rtl/patdet_checker.sv
module patdet_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rx_hold,
   input logic         bit_err,
   input logic         in_sync,
   input logic [W-1:0] snap
);
   // R5
   err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_err |-> $past(in_sync));
   // R9
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hold |=> (!bit_err && $stable(in_sync) && $stable(snap)));
   // R4
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> ($past(!rx_hold) && !bit_err));
   // R7
   loss_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sync) |-> bit_err);
   // R10
   capture_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap) |-> $past(!rx_hold));
endmodule

bind rx_pattern_checker patdet_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_hold(rx_hold), .bit_err(bit_err),
   .in_sync(in_sync), .snap(snap)
);

// File: tb/sim_rx_pattern_checker.sv
module sim_rx_pattern_checker;
   localparam int CLK_NS = 10;

   typedef struct packed {
      logic        rep;
      logic [4:0]  len;
      logic [4:0]  tap;
      logic [5:0]  per;
      logic        cinv;
      logic        dinv;
      logic        lock;
      logic [31:0] pat;
   } row_t;

   // rep len tap period cfg_inv data_inv expect_lock word
   localparam row_t ROWS [7] = '{
      '{1'b0, 5'd6,  5'd5, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0},        // R3 x^7+x^6+1
      '{1'b0, 5'd6,  5'd5, 6'd0,  1'b1, 1'b1, 1'b1, 32'h0},        // R2 inverted, undone
      '{1'b0, 5'd6,  5'd5, 6'd0,  1'b0, 1'b1, 1'b0, 32'h0},        // R2 inverted, not undone
      '{1'b0, 5'd8,  5'd4, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0},        // R3 x^9+x^5+1
      '{1'b1, 5'd7,  5'd0, 6'd8,  1'b0, 1'b0, 1'b1, 32'hA7},       // R3 8-bit word
      '{1'b1, 5'd31, 5'd0, 6'd32, 1'b1, 1'b1, 1'b1, 32'hDEADBEEF}, // R3 32-bit word
      '{1'b1, 5'd6,  5'd0, 6'd5,  1'b0, 1'b0, 1'b0, 32'h16}        // R3 wrong period
   };

   logic clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic rst_n = 1'b0, rx_bit = 1'b0, rx_hold = 1'b0, rx_inv = 1'b0;
   logic ld_pin = 1'b0, ld_ctl = 1'b0, cfg_rep = 1'b0;
   logic [4:0] cfg_len = 5'd6, cfg_tap = 5'd5;
   logic bit_err, in_sync;
   logic [31:0] snap;

   rx_pattern_checker u0 (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_hold(rx_hold), .rx_inv(rx_inv),
      .ld_pin(ld_pin), .ld_ctl(ld_ctl), .cfg_rep(cfg_rep), .cfg_len(cfg_len),
      .cfg_tap(cfg_tap), .bit_err(bit_err), .in_sync(in_sync), .snap(snap)
   );

   int checks = 0, fails = 0, errp = 0, gt = 0;
   bit done = 1'b0;
   logic [31:0] gh = 32'h1, sent = '0, expv;
   row_t cur;

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic step(input logic b);
      rx_bit = b;
      if (!rx_hold) sent = {sent[30:0], b ^ rx_inv};
      @(posedge clk);
      @(negedge clk);
      errp += int'(bit_err);
   endtask

   task automatic next_bit(output logic b);
      if (cur.rep) b = cur.pat[gt % int'(cur.per)];
      else         b = gh[cur.len] ^ gh[cur.tap];
      gh = {gh[30:0], b};
      gt++;
   endtask

   task automatic send(input int n, input bit flip);
      logic b;
      for (int i = 0; i < n; i++) begin
         next_bit(b);
         step(b ^ cur.dinv ^ flip);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rx_hold = 1'b0; ld_pin = 1'b0; ld_ctl = 1'b0;
      cfg_rep = cur.rep; cfg_len = cur.len; cfg_tap = cur.tap; rx_inv = cur.cinv;
      gh = 32'h1; gt = 0; sent = '0; errp = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      // table of patterns: R2 R3 R4 R5
      for (int r = 0; r < 7; r++) begin
         cur = ROWS[r];
         do_reset();
         send(63, 1'b0);
         chk(in_sync == 1'b0, $sformatf("R4 row %0d no lock before sample 64", r), in_sync, 0);
         send(1, 1'b0);
         chk(in_sync == cur.lock, $sformatf("R3 row %0d lock at sample 64", r), in_sync, cur.lock);
         send(64, 1'b0);
         chk(in_sync == cur.lock, $sformatf("R2 row %0d lock held", r), in_sync, cur.lock);
         chk(errp == 0, $sformatf("R5 row %0d no error strobes", r), errp, 0);
      end

      // R1 reset state
      cur = ROWS[0];
      do_reset();
      chk(in_sync == 1'b0, "R1 in_sync after reset", in_sync, 0);
      chk(bit_err == 1'b0, "R1 bit_err after reset", bit_err, 0);
      chk(snap == '0, "R1 snap after reset", snap, 0);

      // R6 R7: errors while locked
      send(64, 1'b0);
      send(5, 1'b0);                         // samples 65..69
      send(1, 1'b1);                         // sample 70
      chk(bit_err == 1'b1, "R5 strobe after flipped bit", bit_err, 1);
      send(1, 1'b0);
      chk(bit_err == 1'b0, "R5 strobe lasts one cycle", bit_err, 0);
      errp = 0;
      send(4, 1'b1);                         // samples 72..75, block 0 has 5
      chk(errp == 4, "R6 one pulse per flipped bit", errp, 4);
      chk(in_sync == 1'b1, "R7 five errors keep lock", in_sync, 1);
      send(114, 1'b0);                       // samples 76..189
      send(6, 1'b1);                         // 190..192 block 1, 193..195 block 2
      chk(in_sync == 1'b1, "R7 errors across blocks kept apart", in_sync, 1);
      send(4, 1'b0);                         // 196..199
      send(2, 1'b1);                         // 200, 201: five in block 2
      chk(in_sync == 1'b1, "R7 five in block still locked", in_sync, 1);
      send(1, 1'b1);                         // 202: sixth
      chk(in_sync == 1'b0, "R7 sixth error drops lock", in_sync, 0);
      chk(bit_err == 1'b1, "R7 sixth error flagged", bit_err, 1);

      // R8 re-acquisition
      errp = 0;
      send(63, 1'b0);
      chk(in_sync == 1'b0, "R8 no relock before 64 samples", in_sync, 0);
      chk(errp == 0, "R5 no strobe while acquiring", errp, 0);
      send(1, 1'b0);
      chk(in_sync == 1'b1, "R8 relock after 64 samples", in_sync, 1);

      // R9 R11 hold
      expv = snap;
      rx_hold = 1'b1;
      ld_pin = 1'b1;
      errp = 0;
      for (int i = 0; i < 10; i++) step(i[0]);
      chk(errp == 0, "R9 no strobe during hold", errp, 0);
      chk(in_sync == 1'b1, "R9 lock kept during hold", in_sync, 1);
      chk(snap == expv, "R11 no capture during hold", snap, expv);
      rx_hold = 1'b0;
      expv = sent;
      send(1, 1'b0);
      chk(snap == expv, "R11 held strobe captured after hold", snap, expv);
      ld_pin = 1'b0;
      send(40, 1'b0);
      chk(errp == 0, "R9 stream resumes clean", errp, 0);

      // R10 capture
      expv = sent;
      ld_ctl = 1'b1;
      send(1, 1'b0);
      chk(snap == expv, "R10 control-bit capture", snap, expv);
      send(3, 1'b0);
      chk(snap == expv, "R10 level does not recapture", snap, expv);
      ld_ctl = 1'b0;
      send(5, 1'b0);
      expv = sent;
      ld_pin = 1'b1;
      send(1, 1'b0);
      chk(snap == expv, "R10 pin capture", snap, expv);
      ld_pin = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule